// File: doc/BRIEF.md
# Bidirectional Printer Port Register Front End

This block sits between a host register bus and the data, status and control lines of a Centronics-style printer port. The host reaches three registers at fixed offsets from the port base: a data latch at offset 0, a status view at offset 1 and a control register at offset 2. Base-address decoding is done outside the block. Host strobes are active low and are sampled on the block clock. A write lands on the clock edge that sees the write strobe low. Read data is combinational from the selected source while the read strobe is low.

A mode input, taken from bit 7 of a separate port-configuration register, picks between output-only operation and bidirectional operation. In output-only mode the data pins are always driven with the latch. In bidirectional mode, bit 5 of the control register sets the direction of the data pins. When it is 1, the pins are released and a data read returns the live pin value. When it is 0, the pins are driven and a data read returns the latch. The output enable follows the control bit at once, so the held latch value is re-driven without a fresh data write.

Top module: `prt_port_regs`

## Requirements
- R1: After reset the data latch and the control register are 00h. A data read returns 00h, a control read returns C0h, `ctl_out` is 0 and `pd_oe` is 1.
- R2: A write to offset 0 stores `host_wdata` at the clock edge where `host_wr_n` is low, and `pd_out` carries that byte from then on.
- R3: With `cfg_bidir` = 0, `pd_oe` is 1 whatever the direction bit holds, and a data read returns the latch.
- R4: With `cfg_bidir` = 1 and control bit 5 = 0, the pins are driven (`pd_oe` = 1) and a data read returns the latch.
- R5: With `cfg_bidir` = 1 and control bit 5 = 1, `pd_oe` is 0. A data write only updates the latch (visible on `pd_out`), and a data read returns `pd_in`.
- R6: Clearing control bit 5 in bidirectional mode sets `pd_oe` to 1 on the next cycle, with `pd_out` still holding the earlier latch value, and no data write is needed.
- R7: A status read returns {~stat_in[4], stat_in[3:0], 3'b111}. Here stat_in[4] is busy, [3] acknowledge, [2] paper-out, [1] selected and [0] error.
- R8: Control bits 0 to 5 are strobe, autofeed, init, select-in, interrupt-enable and direction. A control read returns {2'b11, bits 5..0}, and `ctl_out` equals bits 3..0.
- R9: A write to offset 1 changes nothing: the status read, the data latch, `pd_out`, `pd_oe` and the control register stay as they were.
- R10: `host_rdata` is 00h while `host_rd_n` is high, and a read of offset 3 returns FFh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_addr | input | 2 | Register offset from the port base |
| host_rd_n | input | 1 | Active-low read strobe |
| host_wr_n | input | 1 | Active-low write strobe |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data |
| cfg_bidir | input | 1 | Bidirectional mode enable (bit 7 of the configuration register) |
| pd_in | input | 8 | Live value on the port data pins |
| pd_out | output | 8 | Data latch value presented to the pins |
| pd_oe | output | 1 | Port data pin output enable |
| stat_in | input | 5 | Busy, acknowledge, paper-out, selected, error |
| ctl_out | output | 4 | Strobe, autofeed, init, select-in |

## Verification
A data read and a data write can occur in the same cycle, and so can a data read and a direction change. The bench holds both strobes low together at offset 0. It expects the read to return the old latch before the edge and the new byte after the edge. The same check is repeated with the pins released, where the read must follow `pd_in` and not the byte just written. Separately, the direction bit is flipped while the latch is held, and the bench judges `pd_oe` and `pd_out` on the cycle after the control write.

// File: rtl/prt_port_pkg.sv
package prt_port_pkg;
   localparam int OFS_DATA = 0;
   localparam int OFS_STAT = 1;
   localparam int OFS_CTRL = 2;

   typedef enum logic [1:0] {
      SEL_DATA = 2'd0,
      SEL_STAT = 2'd1,
      SEL_CTRL = 2'd2,
      SEL_NONE = 2'd3
   } prt_sel_e;
endpackage

// File: rtl/prt_ctl_reg.sv
module prt_ctl_reg #(
   parameter int CW = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [CW-1:0] wdata,
   output logic [CW-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (we) q <= wdata;
   end
endmodule

// File: rtl/prt_data_path.sv
module prt_data_path #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [DW-1:0] wdata,
   input  logic          bidir,
   input  logic          dir_in,
   input  logic [DW-1:0] pd_in,
   output logic [DW-1:0] pd_out,
   output logic          pd_oe,
   output logic [DW-1:0] rd_val
);
   logic [DW-1:0] latch_q;
   logic          sample_pins;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  latch_q <= '0;
      else if (we) latch_q <= wdata;
   end

   // pins are released only when both mode and direction ask for input
   assign sample_pins = bidir & dir_in;
   assign pd_oe       = ~sample_pins;
   assign pd_out      = latch_q;
   assign rd_val      = sample_pins ? pd_in : latch_q;
endmodule

// File: rtl/prt_stat_fmt.sv
module prt_stat_fmt #(
   parameter int DW      = 8,
   parameter int SW      = 5,
   parameter bit INV_MSB = 1'b1
) (
   input  logic [SW-1:0] stat_in,
   output logic [DW-1:0] stat_val
);
   localparam int FILL = DW - SW;
   logic [SW-1:0] shaped;

   generate
      if (INV_MSB) begin : g_inv
         assign shaped = {~stat_in[SW-1], stat_in[SW-2:0]};
      end else begin : g_plain
         assign shaped = stat_in;
      end
   endgenerate

   assign stat_val = {shaped, {FILL{1'b1}}};
endmodule

// File: rtl/prt_port_regs.sv
module prt_port_regs #(
   parameter int DW       = 8,
   parameter int AW       = 2,
   parameter int SW       = 5,
   parameter int CW       = 6,
   parameter int NCTL     = 4,
   parameter int DIR_BIT  = 5,
   parameter bit STAT_INV = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] host_addr,
   input  logic          host_rd_n,
   input  logic          host_wr_n,
   input  logic [DW-1:0] host_wdata,
   output logic [DW-1:0] host_rdata,
   input  logic          cfg_bidir,
   input  logic [DW-1:0] pd_in,
   output logic [DW-1:0] pd_out,
   output logic          pd_oe,
   input  logic [SW-1:0] stat_in,
   output logic [NCTL-1:0] ctl_out
);
   import prt_port_pkg::*;

   localparam int CFILL = DW - CW;

   generate
      if (CW >= DW)      begin : g_bad_cw   $error("control width must be below data width"); end
      if (SW >= DW)      begin : g_bad_sw   $error("status width must be below data width"); end
      if (DIR_BIT >= CW) begin : g_bad_dir  $error("direction bit outside control register"); end
      if (NCTL > CW)     begin : g_bad_nctl $error("more control outputs than control bits"); end
      if (AW < 2)        begin : g_bad_aw   $error("address needs two bits"); end
   endgenerate

   prt_sel_e      sel;
   logic          wr_data, wr_ctrl;
   logic [CW-1:0] ctl_q;
   logic [DW-1:0] data_val, stat_val, ctrl_val;

   always_comb begin
      if      (host_addr == AW'(OFS_DATA)) sel = SEL_DATA;
      else if (host_addr == AW'(OFS_STAT)) sel = SEL_STAT;
      else if (host_addr == AW'(OFS_CTRL)) sel = SEL_CTRL;
      else                                 sel = SEL_NONE;
   end

   assign wr_data = ~host_wr_n & (sel == SEL_DATA);
   assign wr_ctrl = ~host_wr_n & (sel == SEL_CTRL);

   prt_ctl_reg #(.CW(CW)) u_ctl (
      .clk(clk), .rst_n(rst_n), .we(wr_ctrl),
      .wdata(host_wdata[CW-1:0]), .q(ctl_q)
   );

   prt_data_path #(.DW(DW)) u_data (
      .clk(clk), .rst_n(rst_n), .we(wr_data), .wdata(host_wdata),
      .bidir(cfg_bidir), .dir_in(ctl_q[DIR_BIT]), .pd_in(pd_in),
      .pd_out(pd_out), .pd_oe(pd_oe), .rd_val(data_val)
   );

   prt_stat_fmt #(.DW(DW), .SW(SW), .INV_MSB(STAT_INV)) u_stat (
      .stat_in(stat_in), .stat_val(stat_val)
   );

   assign ctrl_val = {{CFILL{1'b1}}, ctl_q};
   assign ctl_out  = ctl_q[NCTL-1:0];

   always_comb begin
      host_rdata = '0;
      if (!host_rd_n) begin
         unique case (sel)
            SEL_DATA: host_rdata = data_val;
            SEL_STAT: host_rdata = stat_val;
            SEL_CTRL: host_rdata = ctrl_val;
            default:  host_rdata = '1;
         endcase
      end
   end
endmodule

// File: rtl/prt_port_regs_chk.sv
module prt_port_regs_chk (
   input logic       clk,
   input logic       rst_n,
   input logic [1:0] host_addr,
   input logic       host_rd_n,
   input logic       host_wr_n,
   input logic [7:0] host_wdata,
   input logic [7:0] host_rdata,
   input logic       cfg_bidir,
   input logic [7:0] pd_out,
   input logic       pd_oe,
   input logic [3:0] ctl_out
);
   assert_latch_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!host_wr_n && host_addr == 2'd0) |=> (pd_out == $past(host_wdata)));

   assert_compat_drive_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_bidir |-> pd_oe);

   assert_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!host_wr_n && host_addr == 2'd2 && host_wdata[5] && cfg_bidir)
      |=> (!pd_oe || !cfg_bidir));

   assert_redrive_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(pd_oe) && !$past(!host_wr_n && host_addr == 2'd0)) |-> $stable(pd_out));

   assert_stat_fill_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!host_rd_n && host_addr == 2'd1) |-> (host_rdata[2:0] == 3'b111));

   assert_ctl_upper_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!host_rd_n && host_addr == 2'd2) |-> (host_rdata[7:6] == 2'b11));

   assert_stat_wr_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!host_wr_n && host_addr == 2'd1) |=> ($stable(pd_out) && $stable(ctl_out)));

   assert_idle_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
      host_rd_n |-> (host_rdata == 8'h00));
endmodule

bind prt_port_regs prt_port_regs_chk u_chk (
   .clk(clk), .rst_n(rst_n), .host_addr(host_addr[1:0]),
   .host_rd_n(host_rd_n), .host_wr_n(host_wr_n),
   .host_wdata(host_wdata[7:0]), .host_rdata(host_rdata[7:0]),
   .cfg_bidir(cfg_bidir), .pd_out(pd_out[7:0]), .pd_oe(pd_oe),
   .ctl_out(ctl_out[3:0])
);

// File: tb/prt_port_regs_test.sv
module prt_port_regs_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] host_addr = '0;
   logic       host_rd_n = 1'b1;
   logic       host_wr_n = 1'b1;
   logic [7:0] host_wdata = '0;
   logic [7:0] host_rdata;
   logic       cfg_bidir = 1'b0;
   logic [7:0] pd_in = '0;
   logic [7:0] pd_out;
   logic       pd_oe;
   logic [4:0] stat_in = '0;
   logic [3:0] ctl_out;

   int total = 0;
   int bad = 0;
   logic [7:0] m_latch = 8'h00;
   logic [5:0] m_ctl = 6'h00;

   always #4 clk = ~clk;

   prt_port_regs uut (
      .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_rd_n(host_rd_n),
      .host_wr_n(host_wr_n), .host_wdata(host_wdata), .host_rdata(host_rdata),
      .cfg_bidir(cfg_bidir), .pd_in(pd_in), .pd_out(pd_out), .pd_oe(pd_oe),
      .stat_in(stat_in), .ctl_out(ctl_out)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      host_addr = a; host_wdata = d; host_wr_n = 1'b0;
      @(negedge clk);
      host_wr_n = 1'b1;
      if (a == 2'd0) m_latch = d;
      if (a == 2'd2) m_ctl = d[5:0];
      #1;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] v);
      host_addr = a; host_rd_n = 1'b0;
      #1 v = host_rdata;
      host_rd_n = 1'b1;
      #1;
   endtask

   function automatic logic [7:0] exp_data();
      return (cfg_bidir && m_ctl[5]) ? pd_in : m_latch;
   endfunction

   initial begin
      #(200000 * 8);
      total++; bad++;
      $display("FAIL watchdog actual=%h expected=%h", 8'h00, 8'h01);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [7:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1 reset state
      rd(2'd0, v); chk("R1 data", v, 8'h00);
      rd(2'd2, v); chk("R1 ctrl", v, 8'hC0);
      chk("R1 ctl_out", {4'h0, ctl_out}, 8'h00);
      chk("R1 pd_oe", {7'h0, pd_oe}, 8'h01);
      // R10 idle read and unused offset
      chk("R10 idle", host_rdata, 8'h00);
      rd(2'd3, v); chk("R10 offset3", v, 8'hFF);

      // R2 R3 R4 R5 sweep over mode, direction and data
      for (int md = 0; md < 2; md++) begin
         for (int dr = 0; dr < 2; dr++) begin
            cfg_bidir = md[0];
            wr(2'd2, {2'b00, dr[0], 5'h00});
            for (int k = 0; k < 16; k++) begin
               pd_in = 8'(k * 29) ^ 8'hC3;
               wr(2'd0, 8'(k * 17) ^ 8'h5A);
               chk("R2 pd_out", pd_out, m_latch);
               chk(md == 0 ? "R3 oe" : (dr == 0 ? "R4 oe" : "R5 oe"),
                   {7'h0, pd_oe}, {7'h0, !(md[0] && dr[0])});
               rd(2'd0, v);
               chk(md == 0 ? "R3 read" : (dr == 0 ? "R4 read" : "R5 read"), v, exp_data());
            end
         end
      end

      // R6 direction flip re-drives held latch
      cfg_bidir = 1'b1;
      wr(2'd0, 8'hA5);
      wr(2'd2, 8'h20);
      chk("R6 released", {7'h0, pd_oe}, 8'h00);
      wr(2'd2, 8'h00);
      chk("R6 redrive oe", {7'h0, pd_oe}, 8'h01);
      chk("R6 held value", pd_out, 8'hA5);

      // same-cycle read and write of data offset, driven then released
      for (int dr = 0; dr < 2; dr++) begin
         wr(2'd2, {2'b00, dr[0], 5'h00});
         pd_in = 8'h3C;
         @(negedge clk);
         host_addr = 2'd0; host_wdata = 8'h96 ^ 8'(dr); host_wr_n = 1'b0; host_rd_n = 1'b0;
         #1 chk(dr == 0 ? "R4 rw before edge" : "R5 rw before edge", host_rdata, exp_data());
         @(negedge clk);
         host_wr_n = 1'b1;
         m_latch = 8'h96 ^ 8'(dr);
         #1 chk(dr == 0 ? "R4 rw after edge" : "R5 rw after edge", host_rdata, exp_data());
         chk("R2 rw latch", pd_out, m_latch);
         host_rd_n = 1'b1;
         #1;
      end

      // R7 status format over all inputs
      for (int s = 0; s < 32; s++) begin
         stat_in = 5'(s);
         rd(2'd1, v);
         chk("R7 status", v, {~stat_in[4], stat_in[3:0], 3'b111});
      end

      // R8 control over all values
      for (int c = 0; c < 64; c++) begin
         wr(2'd2, {2'(c), 6'(c)});
         rd(2'd2, v);
         chk("R8 ctrl read", v, {2'b11, m_ctl});
         chk("R8 ctl_out", {4'h0, ctl_out}, {4'h0, m_ctl[3:0]});
      end

      // R9 status write ignored
      cfg_bidir = 1'b1;
      wr(2'd2, 8'h0B);
      wr(2'd0, 8'h71);
      stat_in = 5'h12;
      for (int p = 0; p < 2; p++) begin
         @(negedge clk);
         host_addr = 2'd1; host_wdata = p[0] ? 8'hFF : 8'h00; host_wr_n = 1'b0;
         @(negedge clk);
         host_wr_n = 1'b1;
         #1;
         rd(2'd1, v); chk("R9 status", v, {~stat_in[4], stat_in[3:0], 3'b111});
         rd(2'd2, v); chk("R9 ctrl", v, 8'hCB);
         chk("R9 pd_out", pd_out, 8'h71);
         chk("R9 pd_oe", {7'h0, pd_oe}, 8'h01);
      end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule